// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Check

This block keeps the in-flight loads of an out-of-order core in a circular buffer. A load gets a slot at dispatch, and the block hands back the slot index together with the store-queue position the load is ordered behind. When the load executes, its address is written into that slot. Loads leave from the head once the core reports how far it has committed. Loads on a wrong path are removed from the tail after a misspeculation.

When a store executes, the core presents the load-queue index the store captured at dispatch and the store's address line. The block compares that line with every executed load from that index up to the tail, all in parallel. The oldest matching load is latched as the ordering violator and a fault is flagged in the same cycle. The core later reads the violator, and the read also clears it.

A small controller sequences the commit and squash walks. It has three states. In `LQ_IDLE` the queue accepts allocations. `LQ_COMMIT` retires one head entry per cycle. `LQ_SQUASH` drops one tail entry per cycle. The transitions are:
- IDLE→SQUASH when a squash request arrives.
- IDLE→COMMIT when a commit request arrives and no squash is requested.
- COMMIT→IDLE when the head entry is not retireable or the queue is empty.
- SQUASH→IDLE when the newest entry is not younger than the squash bound or the queue is empty.

Top module: `lq_order_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `count`=0), `busy`=0, `viol_valid`=0 and `alloc_idx`=0.
- R2: The queue holds at most DEPTH loads in DEPTH+1 slots. `full` is 1 at DEPTH entries. An allocation request while full gives `alloc_ok`=0 and leaves `count` and `alloc_idx` unchanged.
- R3: An accepted allocation takes slot `alloc_idx` (the tail), and the tail steps to the next slot, wrapping from DEPTH to 0. `alloc_older_none` equals `alloc_sq_empty`. When `alloc_sq_empty`=0, `alloc_older_idx` equals `alloc_sq_tail`.
- R4: A commit request retires head entries one per cycle, oldest first, while the queue is non-empty and the head sequence number is ≤ the bound (unsigned compare). The walk stops at the first larger one. `busy` stays high for the number of retired entries plus one cycle.
- R5: A squash request removes entries one per cycle starting from the newest, while their sequence number is > the bound. The walk stops at the first entry that is not younger, and the tail moves back to the last removed slot. A squash in the same cycle as a commit or an allocation wins, and the other request is dropped.
- R6: A store probe compares `probe_key` with address bits [ADDR_W-1:8] of the executed loads. It covers the slots from `probe_start` up to but not including the tail, in ring order. `probe_fault` is raised combinationally in the probe cycle if any of them matches.
- R7: On a fault, `viol_idx`, `viol_seq` and `viol_addr` describe the first matching load in scan order, and `viol_valid`=1 from the next cycle.
- R8: While a violator is pending, a probe does no search: `probe_fault`=0 and the violator outputs do not change.
- R9: Asserting `viol_read` while `viol_valid`=1 presents the violator in that cycle and clears `viol_valid` in the next cycle.
- R10: A slot whose address has not been written since it was allocated never matches a probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_empty | input | 1 | Store queue currently empty |
| alloc_sq_tail | input | SQ_IDX_W | Current store-queue tail |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot given to the load (current tail) |
| alloc_older_none | output | 1 | Tag: no older stores |
| alloc_older_idx | output | SQ_IDX_W | Tag: store-queue position ordered behind |
| addr_valid | input | 1 | Address write strobe |
| addr_idx | input | IDX_W | Slot receiving the address |
| addr_value | input | ADDR_W | Executed load address |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Newest surviving sequence number |
| probe_valid | input | 1 | Store probe |
| probe_start | input | IDX_W | Load index captured by the store |
| probe_key | input | ADDR_W-8 | Store address bits [ADDR_W-1:8] |
| probe_fault | output | 1 | Ordering violation found this cycle |
| viol_read | input | 1 | Read and clear the violator |
| viol_valid | output | 1 | Violator pending |
| viol_idx | output | IDX_W | Violator slot |
| viol_seq | output | SEQ_W | Violator sequence number |
| viol_addr | output | ADDR_W | Violator address |
| count | output | CNT_W | Number of loads held |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| busy | output | 1 | Commit or squash walk in progress |

## Verification
A head or tail pointer that drifts from the occupancy count shows up right away. `alloc_idx` returns the wrong slot on the next allocation, and `count`, `full` or `empty` disagree with the number of accepted loads. A walk that stops one entry early or late changes `count` and the length of the `busy` window in the same walk, and that window is measured cycle by cycle. A stale executed flag, a wrong scan window or a broken priority pick appears in the probe cycle itself, as a wrong `probe_fault` or, one cycle later, a wrong `viol_idx`. The stimulus sweeps every start offset against every address key across several laps of the ring, so that each wrap position is covered.

// File: rtl/lq_pkg.sv
`timescale 1ns/1ps
package lq_pkg;
    typedef enum logic [1:0] {
        LQ_IDLE   = 2'd0,
        LQ_COMMIT = 2'd1,
        LQ_SQUASH = 2'd2
    } lq_state_e;
endpackage

// File: rtl/lq_ring_ctrl.sv
`timescale 1ns/1ps
module lq_ring_ctrl
    import lq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 8,
    localparam int SLOTS = DEPTH + 1,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic [SEQ_W-1:0] last_seq,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             busy,
    output logic             alloc_ok,
    output logic             pop,
    output logic             drop
);
    lq_state_e        state_q, state_d;
    logic [SEQ_W-1:0] bound_q, bound_d;
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(SLOTS - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] ring_dec(input logic [IDX_W-1:0] i);
        return (i == '0) ? IDX_W'(SLOTS - 1) : i - 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LQ_IDLE;
            bound_q <= '0;
        end else begin
            state_q <= state_d;
            bound_q <= bound_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        bound_d = bound_q;
        unique case (state_q)
            LQ_IDLE: begin
                if (squash_valid) begin
                    state_d = LQ_SQUASH;
                    bound_d = squash_seq;
                end else if (commit_valid) begin
                    state_d = LQ_COMMIT;
                    bound_d = commit_seq;
                end
            end
            LQ_COMMIT: if (!pop)  state_d = LQ_IDLE;
            LQ_SQUASH: if (!drop) state_d = LQ_IDLE;
            default:   state_d = LQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        empty    = (cnt_q == '0);
        full     = (cnt_q == CNT_W'(DEPTH));
        busy     = (state_q != LQ_IDLE);
        last_idx = ring_dec(tail_q);
        pop      = (state_q == LQ_COMMIT) && !empty && (head_seq <= bound_q);
        drop     = (state_q == LQ_SQUASH) && !empty && (last_seq > bound_q);
        alloc_ok = alloc_valid && (state_q == LQ_IDLE) && !full && !squash_valid;
        head_idx = head_q;
        tail_idx = tail_q;
        count    = cnt_q;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc_ok) begin
                tail_q <= ring_inc(tail_q);
                cnt_q  <= cnt_q + 1'b1;
            end
            if (drop) begin
                tail_q <= ring_dec(tail_q);
                cnt_q  <= cnt_q - 1'b1;
            end
            if (pop) begin
                head_q <= ring_inc(head_q);
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH);

    a_r2_ptr_count: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) == (int'(tail_q) + SLOTS - int'(head_q)) % SLOTS);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
        (cnt_q == $past(cnt_q) - 1'b1));

    a_r5_squash_holds_head: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(head_q));
endmodule

// File: rtl/lq_probe.sv
`timescale 1ns/1ps
module lq_probe #(
    parameter int SLOTS = 5,
    parameter int IDX_W = 3,
    parameter int KEY_W = 8
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] tail_idx,
    input  logic [SLOTS-1:0] executed,
    input  logic [KEY_W-1:0] slot_key [SLOTS],
    input  logic [KEY_W-1:0] probe_key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = executed[g] && (slot_key[g] == probe_key);
    end

    // oldest match inside the window [start, tail)
    always_comb begin
        int span;
        int pos;
        hit     = 1'b0;
        hit_idx = '0;
        span = ((int'(tail_idx) - int'(start_idx)) % SLOTS + SLOTS) % SLOTS;
        for (int k = 0; k < SLOTS; k++) begin
            pos = (int'(start_idx) + k) % SLOTS;
            if (!hit && (k < span) && match[pos]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/lq_order_queue.sv
`timescale 1ns/1ps
module lq_order_queue #(
    parameter int DEPTH    = 4,
    parameter int SEQ_W    = 8,
    parameter int ADDR_W   = 16,
    parameter int SQ_IDX_W = 3,
    parameter int CMP_LSB  = 8,
    localparam int SLOTS = DEPTH + 1,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int KEY_W = ADDR_W - CMP_LSB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic                alloc_sq_empty,
    input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
    output logic                alloc_ok,
    output logic [IDX_W-1:0]    alloc_idx,
    output logic                alloc_older_none,
    output logic [SQ_IDX_W-1:0] alloc_older_idx,
    input  logic                addr_valid,
    input  logic [IDX_W-1:0]    addr_idx,
    input  logic [ADDR_W-1:0]   addr_value,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    input  logic                probe_valid,
    input  logic [IDX_W-1:0]    probe_start,
    input  logic [KEY_W-1:0]    probe_key,
    output logic                probe_fault,
    input  logic                viol_read,
    output logic                viol_valid,
    output logic [IDX_W-1:0]    viol_idx,
    output logic [SEQ_W-1:0]    viol_seq,
    output logic [ADDR_W-1:0]   viol_addr,
    output logic [CNT_W-1:0]    count,
    output logic                full,
    output logic                empty,
    output logic                busy
);
    logic [SEQ_W-1:0]  seq_q  [SLOTS];
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic [KEY_W-1:0]  key_w  [SLOTS];
    logic [SLOTS-1:0]  exec_q;
    logic [IDX_W-1:0]  head_idx, tail_idx, last_idx, hit_idx;
    logic              pop, drop, hit;
    logic              vv_q;
    logic [IDX_W-1:0]  vi_q;
    logic [SEQ_W-1:0]  vs_q;
    logic [ADDR_W-1:0] va_q;

    lq_ring_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .head_seq(seq_q[head_idx]), .last_seq(seq_q[last_idx]),
        .head_idx(head_idx), .tail_idx(tail_idx), .last_idx(last_idx),
        .count(count), .full(full), .empty(empty), .busy(busy),
        .alloc_ok(alloc_ok), .pop(pop), .drop(drop)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_key
        assign key_w[g] = addr_q[g][ADDR_W-1:CMP_LSB];
    end

    lq_probe #(.SLOTS(SLOTS), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_probe (
        .start_idx(probe_start), .tail_idx(tail_idx),
        .executed(exec_q), .slot_key(key_w), .probe_key(probe_key),
        .hit(hit), .hit_idx(hit_idx)
    );

    assign alloc_idx        = tail_idx;
    assign alloc_older_none = alloc_sq_empty;
    assign alloc_older_idx  = alloc_sq_empty ? '0 : alloc_sq_tail;
    assign probe_fault      = probe_valid && !vv_q && hit;
    assign viol_valid       = vv_q;
    assign viol_idx         = vi_q;
    assign viol_seq         = vs_q;
    assign viol_addr        = va_q;

    // slot payload
    always_ff @(posedge clk) begin
        if (alloc_ok) seq_q[tail_idx] <= alloc_seq;
        if (addr_valid && (int'(addr_idx) < SLOTS)) addr_q[addr_idx] <= addr_value;
    end

    // executed flags: write sets, allocation and squash clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= '0;
        end else begin
            if (addr_valid && (int'(addr_idx) < SLOTS)) exec_q[addr_idx] <= 1'b1;
            if (alloc_ok) exec_q[tail_idx] <= 1'b0;
            if (drop)     exec_q[last_idx] <= 1'b0;
        end
    end

    // violator register, read-and-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vv_q <= 1'b0;
            vi_q <= '0;
            vs_q <= '0;
            va_q <= '0;
        end else if (probe_fault) begin
            vv_q <= 1'b1;
            vi_q <= hit_idx;
            vs_q <= seq_q[hit_idx];
            va_q <= addr_q[hit_idx];
        end else if (viol_read) begin
            vv_q <= 1'b0;
        end
    end

    a_r6_fault_needs_loads: assert property (@(posedge clk) disable iff (!rst_n)
        probe_fault |-> !empty);

    a_r10_hit_executed: assert property (@(posedge clk) disable iff (!rst_n)
        probe_fault |-> exec_q[hit_idx]);

    a_r8_violator_held: assert property (@(posedge clk) disable iff (!rst_n)
        (vv_q && !viol_read) |=> (vv_q && $stable(vi_q) && $stable(vs_q)));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vv_q && viol_read) |=> !vv_q);
endmodule

// File: tb/lq_order_queue_bench.sv
`timescale 1ns/1ps
module lq_order_queue_bench;
    localparam int DEPTH = 4, SEQ_W = 8, ADDR_W = 16, SQ_IDX_W = 3, CMP_LSB = 8;
    localparam int S = DEPTH + 1, IDX_W = 3, CNT_W = 3, KEY_W = ADDR_W - CMP_LSB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_sq_empty = 0, addr_valid = 0, commit_valid = 0;
    logic squash_valid = 0, probe_valid = 0, viol_read = 0;
    logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
    logic [SQ_IDX_W-1:0] alloc_sq_tail = '0;
    logic [IDX_W-1:0] addr_idx = '0, probe_start = '0;
    logic [ADDR_W-1:0] addr_value = '0;
    logic [KEY_W-1:0] probe_key = '0;
    logic alloc_ok, alloc_older_none, probe_fault, viol_valid, full, empty, busy;
    logic [IDX_W-1:0] alloc_idx, viol_idx;
    logic [SQ_IDX_W-1:0] alloc_older_idx;
    logic [SEQ_W-1:0] viol_seq;
    logic [ADDR_W-1:0] viol_addr;
    logic [CNT_W-1:0] count;

    lq_order_queue u_lq_order_queue (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    int mseq[S], maddr[S];
    bit mexec[S];
    int mhead = 0, mtail = 0, mcnt = 0;
    bit mvv = 0;
    int mvi = 0, mvs = 0, mva = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_alloc(int seq, bit sqe, int sqt);
        int exp_ok;
        alloc_valid = 1; alloc_seq = SEQ_W'(seq);
        alloc_sq_empty = sqe; alloc_sq_tail = SQ_IDX_W'(sqt);
        #1;
        exp_ok = (mcnt < DEPTH) ? 1 : 0;
        chk("R2", "alloc_ok", int'(alloc_ok), exp_ok);
        chk("R3", "alloc_idx", int'(alloc_idx), mtail);
        chk("R3", "older_none", int'(alloc_older_none), int'(sqe));
        if (!sqe) chk("R3", "older_idx", int'(alloc_older_idx), sqt);
        step();
        alloc_valid = 0;
        if (exp_ok == 1) begin
            mseq[mtail] = seq; mexec[mtail] = 0;
            mtail = (mtail + 1) % S; mcnt++;
        end
        chk("R2", "count", int'(count), mcnt);
        chk("R2", "full", int'(full), (mcnt == DEPTH) ? 1 : 0);
    endtask

    task automatic do_addr(int idx, int a);
        addr_valid = 1; addr_idx = IDX_W'(idx); addr_value = ADDR_W'(a);
        step();
        addr_valid = 0;
        mexec[idx] = 1; maddr[idx] = a;
    endtask

    task automatic do_walk(bit use_sq, bit use_cm, int sq_lim, int cm_lim, bit try_alloc);
        int pops = 0, n = 0;
        string req;
        req = use_sq ? "R5" : "R4";
        squash_valid = use_sq; squash_seq = SEQ_W'(sq_lim);
        commit_valid = use_cm; commit_seq = SEQ_W'(cm_lim);
        alloc_valid = try_alloc; alloc_seq = 8'd99;
        #1;
        if (try_alloc) chk("R5", "alloc during squash", int'(alloc_ok), 0);
        step();
        squash_valid = 0; commit_valid = 0; alloc_valid = 0;
        if (use_sq) begin
            while (mcnt > 0 && mseq[(mtail + S - 1) % S] > sq_lim) begin
                mtail = (mtail + S - 1) % S; mexec[mtail] = 0; mcnt--; pops++;
            end
        end else if (use_cm) begin
            while (mcnt > 0 && mseq[mhead] <= cm_lim) begin
                mhead = (mhead + 1) % S; mcnt--; pops++;
            end
        end
        while (busy === 1'b1 && n < 40) begin n++; step(); end
        chk(req, "busy cycles", n, pops + 1);
        chk(req, "count after walk", int'(count), mcnt);
        chk(req, "tail after walk", int'(alloc_idx), mtail);
        chk(req, "empty", int'(empty), (mcnt == 0) ? 1 : 0);
    endtask

    task automatic do_probe(int start, int key);
        int span, p, ef = 0, ei = 0;
        span = ((mtail - start) % S + S) % S;
        if (!mvv) begin
            for (int k = 0; k < span; k++) begin
                p = (start + k) % S;
                if (ef == 0 && mexec[p] && ((maddr[p] >> 8) & 255) == key) begin
                    ef = 1; ei = p;
                end
            end
        end
        probe_valid = 1; probe_start = IDX_W'(start); probe_key = KEY_W'(key);
        #1;
        chk(mvv ? "R8" : "R6", "probe_fault", int'(probe_fault), ef);
        step();
        probe_valid = 0;
        if (ef == 1) begin
            mvv = 1; mvi = ei; mvs = mseq[ei]; mva = maddr[ei];
        end
        chk("R7", "viol_valid", int'(viol_valid), int'(mvv));
        if (mvv) begin
            chk("R7", "viol_idx", int'(viol_idx), mvi);
            chk("R7", "viol_seq", int'(viol_seq), mvs);
            chk("R7", "viol_addr", int'(viol_addr), mva);
        end
    endtask

    task automatic do_read();
        viol_read = 1;
        #1;
        chk("R9", "viol_valid at read", int'(viol_valid), int'(mvv));
        if (mvv) chk("R9", "viol_seq at read", int'(viol_seq), mvs);
        step();
        viol_read = 0; mvv = 0;
        chk("R9", "viol cleared", int'(viol_valid), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int base, pos[4];
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "count", int'(count), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "viol_valid", int'(viol_valid), 0);
        chk("R1", "alloc_idx", int'(alloc_idx), 0);

        for (int r = 0; r < 6; r++) begin
            base = 10 + r * 20;
            for (int k = 0; k < 4; k++) begin
                pos[k] = mtail;
                do_alloc(base + 2 * k, (k == 0), k);
            end
            do_alloc(base + 9, 0, 5);                 // R2 rejected while full
            for (int k = 0; k < 3; k++) begin         // slot 3 left unexecuted (R10)
                int up;
                up = (k == 2 && (r % 2) == 1) ? (2 + r * 4) : (k + 1 + r * 4);
                do_addr(pos[k], ((up & 255) << 8) | ((k * 37 + r) & 255));
            end
            for (int s = 0; s < S; s++) begin
                for (int t = 0; t < 5; t++) begin
                    int key;
                    key = (t == 4) ? 8'hEE : ((t + 1 + r * 4) & 255);
                    do_probe((mhead + s) % S, key);
                    if (mvv) do_read();
                end
            end
            // R8: pending violator blocks the next search
            do_probe(mhead, (1 + r * 4) & 255);
            do_probe(mhead, (2 + r * 4) & 255);
            do_read();
            // R5: squash the two youngest
            do_walk(1, 0, base + 3, 0, 0);
            // R10: reallocated slot loses its executed flag
            do_alloc(base + 5, 0, 1);
            do_probe(mhead, (3 + r * 4) & 255);
            if (mvv) do_read();
            // R4: partial then full commit
            do_walk(0, 1, 0, base + 1, 0);
            do_walk(0, 1, 0, 255, 0);
        end

        // R5 priority over commit and allocation
        do_alloc(200, 1, 0);
        do_alloc(210, 0, 2);
        do_walk(1, 1, 205, 255, 1);
        do_walk(0, 1, 0, 255, 0);
        do_walk(1, 0, 0, 0, 0);                       // squash on empty queue

        done = 1;
        finish_run();
    end
endmodule